// File: doc/BRIEF.md
# Tag Inventory Slot Arbiter

This block decides when a passive identification tag may answer during an inventory round. A command decoder upstream hands it one decoded strobe per clock: start-of-round, next-slot, acknowledge, a reply-timeout pulse, a population select, and three access-stage strobes (open, secure, kill). The arbiter keeps a 15-bit slot counter, tracks the tag's protocol state, holds one inventoried flag for each of four sessions, and raises a one-cycle reply request when the tag should backscatter.

When a round starts, the slot counter is loaded from an on-chip pseudo-random source. The tag may reply only when its count is zero: either right after the load or after enough next-slot commands. A reply that is not acknowledged before the timeout sends the tag back to arbitration. A tag that is acknowledged, or taken further into access, has the inventoried flag of its round's session inverted when the next round begins. Once the tag is killed, nothing changes it again.

Top module: `tag_slot_arbiter`

## Requirements
- R1: After reset, state_o is 0 (Ready), slot_o is 0, inv_flags_o is 0 and reply_o is 0. State codes: Ready 0, Arbitrate 1, Reply 2, Acknowledged 3, Open 4, Secured 5, Killed 6. Bit i of inv_flags_o is the flag of session i.
- R2: The random source is a 16-bit register that resets to SEED and shifts left on every clock. The new bit 0 is the XOR of bits 15, 13, 12 and 10. A round start loads bits 14:0 of the value the register holds at that clock edge into the slot counter.
- R3: A round start (query_i) in any non-killed state records query_sess_i as the round's session. If the loaded value is 0, the next cycle shows state Reply with reply_o high for exactly that one cycle. Otherwise it shows state Arbitrate with reply_o low.
- R4: qrep_i in Arbitrate decrements the slot counter. When the count goes from 1 to 0, the state becomes Reply and reply_o pulses; reply_o is only ever high while slot_o is 0.
- R5: qrep_i in any state other than Arbitrate changes neither state nor slot.
- R6: ack_i in Reply moves the tag to Acknowledged. In any other state it is ignored.
- R7: timeout_i in Reply returns the tag to Arbitrate and decrements the slot counter; a count of 0 wraps to 15'h7FFF with no reply. In any other state timeout_i is ignored.
- R8: A round start from Acknowledged, Open or Secured inverts the flag of the previous round's session before the new round begins. From Ready, Arbitrate or Reply no flag changes.
- R9: sel_i writes sel_flag_i into the flag of session sel_sess_i and returns the tag to Ready, leaving the slot counter unchanged. Flags change only on sel_i or a round start.
- R10: open_i moves Acknowledged to Open, secure_i moves Open to Secured, and kill_i moves Open or Secured to Killed. In any other state these strobes are ignored.
- R11: Killed is permanent. No strobe changes the state or the flags, and reply_o stays low.
- R12: When several strobes arrive together, one is served by priority: query_i, qrep_i, ack_i, timeout_i, sel_i, open_i, secure_i, kill_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| query_i | input | 1 | Round-start strobe |
| query_sess_i | input | 2 | Session of the new round |
| qrep_i | input | 1 | Next-slot strobe |
| ack_i | input | 1 | Acknowledge strobe |
| timeout_i | input | 1 | Reply-timeout pulse |
| sel_i | input | 1 | Population-select strobe |
| sel_sess_i | input | 2 | Session whose flag the select writes |
| sel_flag_i | input | 1 | Flag value the select writes |
| open_i | input | 1 | Acknowledged-to-Open strobe |
| secure_i | input | 1 | Open-to-Secured strobe |
| kill_i | input | 1 | Kill strobe |
| state_o | output | 3 | Protocol state code |
| slot_o | output | 15 | Slot counter |
| inv_flags_o | output | 4 | Inventoried flag per session |
| reply_o | output | 1 | One-cycle reply request |

## Verification
Every output is a register, so each result of a strobe is due at the first rising edge after it and is gone or replaced one edge later. The bench applies each strobe on a falling edge and checks state, slot, flags and reply on the next falling edge. It then checks reply_o once more a cycle later to confirm the pulse has ended. The expected slot after a round start comes from a bench model of the random register, read on the same falling edge on which the strobe is driven, because that is the value the design samples at the following rising edge.

// File: rtl/tag_arb_pkg.sv
package tag_arb_pkg;

  typedef enum logic [2:0] {
    ST_READY   = 3'd0,
    ST_ARB     = 3'd1,
    ST_REPLY   = 3'd2,
    ST_ACKED   = 3'd3,
    ST_OPEN    = 3'd4,
    ST_SECURED = 3'd5,
    ST_KILLED  = 3'd6
  } tag_state_e;

endpackage

// File: rtl/tag_lfsr.sv
module tag_lfsr #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    TAPS = 16'hB400,
  parameter logic [W-1:0]    SEED = 16'h0001
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= SEED;
    else         q_q <= {q_q[W-2:0], ^(q_q & TAPS)};
  end

  assign q_o = q_q;

  // a nonzero seed never reaches the all-zero lock-up value
  assert_lfsr_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q != '0);

endmodule

// File: rtl/tag_slot_ctr.sv
module tag_slot_ctr #(
  parameter int SLOT_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              dec_i,
  input  logic [SLOT_W-1:0] load_val_i,
  output logic [SLOT_W-1:0] count_o,
  output logic              load_val_zero_o,
  output logic              count_is_one_o
);

  logic [SLOT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (dec_i)  count_q <= count_q - SLOT_W'(1);
  end

  assign count_o         = count_q;
  assign load_val_zero_o = (load_val_i == '0);
  assign count_is_one_o  = (count_q == SLOT_W'(1));

  assert_slot_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && count_q == '0) |=> count_q == '1);

endmodule

// File: rtl/tag_inv_fsm.sv
module tag_inv_fsm
  import tag_arb_pkg::*;
#(
  parameter int NUM_SESS = 4,
  localparam int SESS_W  = $clog2(NUM_SESS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                query_i,
  input  logic [SESS_W-1:0]   query_sess_i,
  input  logic                qrep_i,
  input  logic                ack_i,
  input  logic                timeout_i,
  input  logic                sel_i,
  input  logic [SESS_W-1:0]   sel_sess_i,
  input  logic                sel_flag_i,
  input  logic                open_i,
  input  logic                secure_i,
  input  logic                kill_i,
  input  logic                load_zero_i,
  input  logic                slot_one_i,
  output logic                load_o,
  output logic                dec_o,
  output tag_state_e          state_o,
  output logic [NUM_SESS-1:0] flags_o,
  output logic                reply_o
);

  tag_state_e          state_q, state_d;
  logic [NUM_SESS-1:0] flags_q, flags_d;
  logic [SESS_W-1:0]   sess_q, sess_d;
  logic                reply_q, reply_d;

  // one strobe served per clock, fixed priority
  always_comb begin
    state_d = state_q;
    flags_d = flags_q;
    sess_d  = sess_q;
    reply_d = 1'b0;
    load_o  = 1'b0;
    dec_o   = 1'b0;
    if (state_q != ST_KILLED) begin
      if (query_i) begin
        load_o = 1'b1;
        sess_d = query_sess_i;
        if (state_q inside {ST_ACKED, ST_OPEN, ST_SECURED})
          flags_d[sess_q] = ~flags_q[sess_q];
        if (load_zero_i) begin
          state_d = ST_REPLY;
          reply_d = 1'b1;
        end else begin
          state_d = ST_ARB;
        end
      end else if (qrep_i) begin
        if (state_q == ST_ARB) begin
          dec_o = 1'b1;
          if (slot_one_i) begin
            state_d = ST_REPLY;
            reply_d = 1'b1;
          end
        end
      end else if (ack_i) begin
        if (state_q == ST_REPLY) state_d = ST_ACKED;
      end else if (timeout_i) begin
        if (state_q == ST_REPLY) begin
          state_d = ST_ARB;
          dec_o   = 1'b1;
        end
      end else if (sel_i) begin
        flags_d[sel_sess_i] = sel_flag_i;
        state_d             = ST_READY;
      end else if (open_i) begin
        if (state_q == ST_ACKED) state_d = ST_OPEN;
      end else if (secure_i) begin
        if (state_q == ST_OPEN) state_d = ST_SECURED;
      end else if (kill_i) begin
        if (state_q inside {ST_OPEN, ST_SECURED}) state_d = ST_KILLED;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READY;
      flags_q <= '0;
      sess_q  <= '0;
      reply_q <= 1'b0;
    end else begin
      state_q <= state_d;
      flags_q <= flags_d;
      sess_q  <= sess_d;
      reply_q <= reply_d;
    end
  end

  assign state_o = state_q;
  assign flags_o = flags_q;
  assign reply_o = reply_q;

  assert_killed_absorbing_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_KILLED |=> state_q == ST_KILLED);

  assert_reply_in_reply_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_q |-> state_q == ST_REPLY);

  assert_ack_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !query_i && !qrep_i && state_q != ST_REPLY) |=> state_q == $past(state_q));

  assert_flags_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(query_i || sel_i) |=> $stable(flags_q));

endmodule

// File: rtl/tag_slot_arbiter.sv
module tag_slot_arbiter
  import tag_arb_pkg::*;
#(
  parameter int                LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] TAPS     = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED     = 16'h0001,
  parameter int                SLOT_W   = 15,
  parameter int                NUM_SESS = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        query_i,
  input  logic [$clog2(NUM_SESS)-1:0] query_sess_i,
  input  logic                        qrep_i,
  input  logic                        ack_i,
  input  logic                        timeout_i,
  input  logic                        sel_i,
  input  logic [$clog2(NUM_SESS)-1:0] sel_sess_i,
  input  logic                        sel_flag_i,
  input  logic                        open_i,
  input  logic                        secure_i,
  input  logic                        kill_i,
  output logic [2:0]                  state_o,
  output logic [SLOT_W-1:0]           slot_o,
  output logic [NUM_SESS-1:0]         inv_flags_o,
  output logic                        reply_o
);

  logic [LFSR_W-1:0] rnd;
  logic              load, dec, load_zero, slot_one;
  tag_state_e        state;

  tag_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .q_o    (rnd)
  );

  tag_slot_ctr #(.SLOT_W(SLOT_W)) u_slot (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .load_i          (load),
    .dec_i           (dec),
    .load_val_i      (rnd[SLOT_W-1:0]),
    .count_o         (slot_o),
    .load_val_zero_o (load_zero),
    .count_is_one_o  (slot_one)
  );

  tag_inv_fsm #(.NUM_SESS(NUM_SESS)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .query_i      (query_i),
    .query_sess_i (query_sess_i),
    .qrep_i       (qrep_i),
    .ack_i        (ack_i),
    .timeout_i    (timeout_i),
    .sel_i        (sel_i),
    .sel_sess_i   (sel_sess_i),
    .sel_flag_i   (sel_flag_i),
    .open_i       (open_i),
    .secure_i     (secure_i),
    .kill_i       (kill_i),
    .load_zero_i  (load_zero),
    .slot_one_i   (slot_one),
    .load_o       (load),
    .dec_o        (dec),
    .state_o      (state),
    .flags_o      (inv_flags_o),
    .reply_o      (reply_o)
  );

  assign state_o = state;

  assert_reply_slot_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_o |-> slot_o == '0);

endmodule

// File: tb/tag_slot_arbiter_tb.sv
module tag_slot_arbiter_tb;

  localparam logic [15:0] SEED = 16'h8000;
  localparam logic [2:0] S_READY = 3'd0, S_ARB = 3'd1, S_REPLY = 3'd2, S_ACKED = 3'd3,
                         S_OPEN = 3'd4, S_SECURED = 3'd5, S_KILLED = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        q = 0, rp = 0, ak = 0, to = 0, sl = 0, sf = 0, op = 0, se = 0, kl = 0;
  logic [1:0]  qs = 0, ss = 0;
  logic [2:0]  state;
  logic [14:0] slot;
  logic [3:0]  flags;
  logic        reply;

  int          n_chk = 0, n_fail = 0;
  logic [2:0]  exp_state = S_READY;
  logic [14:0] exp_slot = '0;
  logic [3:0]  exp_flags = '0;
  logic [1:0]  cur_sess = '0;
  logic [15:0] mdl;
  bit          done = 0;

  always #5 clk = ~clk;

  // independent model of the random source (R2)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdl <= SEED;
    else        mdl <= {mdl[14:0], mdl[15] ^ mdl[13] ^ mdl[12] ^ mdl[10]};
  end

  tag_slot_arbiter #(.SEED(SEED)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .query_i(q), .query_sess_i(qs), .qrep_i(rp), .ack_i(ak), .timeout_i(to),
    .sel_i(sl), .sel_sess_i(ss), .sel_flag_i(sf),
    .open_i(op), .secure_i(se), .kill_i(kl),
    .state_o(state), .slot_o(slot), .inv_flags_o(flags), .reply_o(reply)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic exp_reply);
    cmp(req, "state", int'(state), int'(exp_state));
    cmp(req, "slot", int'(slot), int'(exp_slot));
    cmp(req, "flags", int'(flags), int'(exp_flags));
    cmp(req, "reply", int'(reply), int'(exp_reply));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    q = 0; rp = 0; ak = 0; to = 0; sl = 0; sf = 0; op = 0; se = 0; kl = 0;
  endtask

  task automatic do_query(input logic [1:0] s, input string req);
    logic [14:0] v;
    v = mdl[14:0];
    if (exp_state inside {S_ACKED, S_OPEN, S_SECURED}) exp_flags[cur_sess] = ~exp_flags[cur_sess];
    cur_sess = s;
    q = 1; qs = s;
    tick();
    exp_slot  = v;
    exp_state = (v == 0) ? S_REPLY : S_ARB;
    check_all(req, v == 0);
  endtask

  task automatic rep_step(input string req);
    logic hit;
    hit = (exp_state == S_ARB) && (exp_slot == 15'd1);
    if (exp_state == S_ARB) exp_slot = exp_slot - 15'd1;
    if (hit) exp_state = S_REPLY;
    rp = 1;
    tick();
    check_all(req, hit);
  endtask

  task automatic reach_reply(input logic [1:0] s);
    while (!(mdl[14:0] >= 15'd1 && mdl[14:0] <= 15'd7)) @(negedge clk);
    do_query(s, "R2 small load");
    while (exp_state == S_ARB) rep_step("R4 count to zero");
    cmp("R4", "reached reply", int'(state), int'(S_REPLY));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check_all("R1 reset", 1'b0);
  endtask

  task automatic t_zero_load();
    rst_n = 1;
    do_query(2'd0, "R3 zero load");
    tick();
    cmp("R3", "pulse one cycle", int'(reply), 0);
  endtask

  task automatic t_ack_and_access();
    rp = 1; tick();
    check_all("R5 qrep in Reply ignored", 1'b0);
    ak = 1; tick(); exp_state = S_ACKED;
    check_all("R6 ack in Reply", 1'b0);
    rp = 1; tick();
    check_all("R5 qrep in Acknowledged ignored", 1'b0);
    op = 1; tick(); exp_state = S_OPEN;
    check_all("R10 open", 1'b0);
    se = 1; tick(); exp_state = S_SECURED;
    check_all("R10 secure", 1'b0);
  endtask

  task automatic t_flip_and_arb();
    do_query(2'd1, "R8 flip from Secured");
    cmp("R8", "flag0", int'(flags[0]), 1);
    if (exp_state == S_ARB && exp_slot > 15'd1) begin
      rep_step("R4 decrement");
      ak = 1; tick();
      check_all("R6 ack in Arbitrate ignored", 1'b0);
      to = 1; tick();
      check_all("R7 timeout in Arbitrate ignored", 1'b0);
    end
  endtask

  task automatic t_select();
    sl = 1; ss = 2'd3; sf = 1; tick();
    exp_flags[3] = 1'b1; exp_state = S_READY;
    check_all("R9 select", 1'b0);
    op = 1; tick();
    check_all("R10 open in Ready ignored", 1'b0);
    rp = 1; tick();
    check_all("R5 qrep in Ready ignored", 1'b0);
    ak = 1; tick();
    check_all("R6 ack in Ready ignored", 1'b0);
    kl = 1; tick();
    check_all("R10 kill in Ready ignored", 1'b0);
  endtask

  task automatic t_timeout();
    reach_reply(2'd2);
    to = 1; tick();
    exp_state = S_ARB; exp_slot = 15'h7FFF;
    check_all("R7 timeout wraps", 1'b0);
    rep_step("R4 decrement after wrap");
  endtask

  task automatic t_priority();
    logic [14:0] v;
    reach_reply(2'd2);
    ak = 1; to = 1; tick();
    exp_state = S_ACKED;
    check_all("R12 ack over timeout", 1'b0);
    v = mdl[14:0];
    exp_flags[cur_sess] = ~exp_flags[cur_sess];
    cur_sess = 2'd1;
    q = 1; qs = 2'd1; op = 1; tick();
    exp_slot = v; exp_state = (v == 0) ? S_REPLY : S_ARB;
    check_all("R12 query over open, R8 flip", v == 0);
  endtask

  task automatic t_kill();
    logic [3:0] kf;
    reach_reply(2'd0);
    ak = 1; tick(); exp_state = S_ACKED;
    check_all("R6 ack", 1'b0);
    op = 1; tick(); exp_state = S_OPEN;
    check_all("R10 open", 1'b0);
    kl = 1; tick(); exp_state = S_KILLED;
    check_all("R10 kill from Open", 1'b0);
    kf = exp_flags;
    q = 1; qs = 2'd0; tick();
    check_all("R11 query in Killed", 1'b0);
    sl = 1; ss = 2'd1; sf = ~kf[1]; tick();
    check_all("R11 select in Killed", 1'b0);
    rp = 1; tick();
    check_all("R11 qrep in Killed", 1'b0);
    ak = 1; to = 1; tick();
    check_all("R11 ack/timeout in Killed", 1'b0);
  endtask

  initial begin
    t_reset();
    t_zero_load();
    t_ack_and_access();
    t_flip_and_arb();
    t_select();
    t_timeout();
    t_priority();
    t_kill();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule